// File: doc/BRIEF.md
# Stepped-Phase Sine Oscillator

This block produces a digital sine wave whose frequency is set by a small unsigned step input. A 10-bit phase register advances by eight times the step. Each 10-bit phase value selects one entry of a 1024-point table of signed 18-bit sine values. The table is filled at elaboration time and is held in a single synchronous ROM, which maps to a block RAM.

The phase does not advance on every clock. A free-running divider issues an update tick once every 195 clocks. Each tick moves the phase once and starts one table read. The sample that comes out of the read is presented together with a valid strobe that is high for exactly one clock. Downstream logic, such as a filter or a slow converter, takes one sample per strobe. Between strobes the sample output holds its last value.

Top module: `sine_nco`

## Requirements
- R1: The reset `rst_n` is active low and synchronous. While it is low, `sample` reads 0 and `sample_vld` reads 0. It also clears the phase and the tick divider to zero.
- R2: Each update sets the phase to (phase + 8*step) mod 1024. The step is the 6-bit unsigned value of `step` at that update.
- R3: The sample presented with each strobe is the table entry at the freshly updated phase p. That entry is round-to-nearest(131071 * sin(2*pi*p/1024)), in two's complement.
- R4: The first `sample_vld` after reset is seen 196 clock edges after the first edge that samples `rst_n` high. `sample` carries the new value in that same cycle.
- R5: After the first strobe, `sample_vld` is asserted exactly every 195 clocks.
- R6: `sample_vld` is never high on two consecutive clocks.
- R7: `sample` changes only in a cycle where `sample_vld` is high.
- R8: With a step of 0, every strobe carries the same value, and strobes keep arriving at the normal 195-clock spacing.
- R9: With the largest step (63, an advance of 504), the phase wraps through 1024 with no glitch in value or timing.
- R10: A change on `step` between two updates takes effect at the next update, and only there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 6 | Unsigned frequency step; the phase advance is 8*step |
| sample | output | 18 | Signed sine sample, held between strobes |
| sample_vld | output | 1 | One-clock strobe marking a new sample |

## Verification
A wrong phase value shows up at the next strobe, at most 195 clocks later, as a sample that differs from the expected sine entry. Because the phase accumulates, that error then persists in every later sample. A divider that miscounts moves the strobe off its 195-clock grid on the very next period. A wrong table entry shows only when the phase lands on that entry. For this reason the stimulus uses odd steps, the largest step (which wraps the phase) and a quarter-turn step, so that many different addresses are read.

// File: rtl/nco_pkg.sv
// nco_pkg: shared constants and the elaboration-time sine generator.
// Assumes sample widths up to 31 bits so results fit in an int.
package nco_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Round-to-nearest sine point for table index idx of a 2^phase_w table.
    function automatic int sine_point(input int idx, input int phase_w, input int sample_w);
        real amp;
        real val;
        amp = (2.0 ** (sample_w - 1)) - 1.0;
        val = amp * $sin(TWO_PI * real'(idx) / (2.0 ** phase_w));
        if (val >= 0.0) begin
            return $rtoi(val + 0.5);
        end
        return -$rtoi(0.5 - val);
    endfunction

endpackage

// File: rtl/nco_tick_gen.sv
// nco_tick_gen: free-running divider that emits a one-clock tick every
// PERIOD clocks. Assumes PERIOD >= 2. Reset restarts the count at zero.
module nco_tick_gen #(
    parameter int PERIOD = 195
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count 0..PERIOD-1 and wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: divider never leaves its range and restarts after each tick.
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));

endmodule

// File: rtl/nco_phase_acc.sv
// nco_phase_acc: phase register advancing by step << SHIFT on each tick,
// wrapping modulo 2^PHASE_W. Assumes STEP_W + SHIFT <= PHASE_W.
module nco_phase_acc #(
    parameter int STEP_W  = 6,
    parameter int PHASE_W = 10,
    parameter int SHIFT   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [STEP_W-1:0]  step,
    output logic [PHASE_W-1:0] phase
);
    logic [PHASE_W-1:0] inc;

    // Scale the step to a phase increment.
    always_comb begin
        inc = PHASE_W'(step) << SHIFT;
    end

    // Advance the phase only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick) begin
            phase <= phase + inc;
        end
    end

    // R2: phase moves by the scaled step on a tick and holds otherwise.
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick) && $past(rst_n) |-> phase == PHASE_W'($past(phase) + (PHASE_W'($past(step)) << SHIFT)));
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) && $past(rst_n) |-> $stable(phase));

endmodule

// File: rtl/nco_sine_rom.sv
// nco_sine_rom: synchronous ROM of 2^ADDR_W signed sine points, filled at
// elaboration. One registered read cycle; output reset to zero.
module nco_sine_rom #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [DATA_W-1:0] data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic signed [DATA_W-1:0] mem [DEPTH];

    // Fill the table once at elaboration.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = DATA_W'(nco_pkg::sine_point(i, ADDR_W, DATA_W));
        end
    end

    // Registered read; output port of the RAM resets to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (rd_en) begin
            data <= mem[addr];
        end
    end

    // R7: read port output only moves on a read.
    a_r7_rom_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(rd_en) |-> $stable(data));

endmodule

// File: rtl/sine_nco.sv
// sine_nco: stepped-phase sine oscillator. A divider ticks every TICK_PERIOD
// clocks; the tick advances the phase, the next clock reads the table, and
// the strobe is delayed by the same one cycle so data and strobe coincide.
module sine_nco #(
    parameter int STEP_W      = 6,
    parameter int PHASE_W     = 10,
    parameter int SAMPLE_W    = 18,
    parameter int STEP_SHIFT  = 3,
    parameter int TICK_PERIOD = 195
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [STEP_W-1:0]          step,
    output logic signed [SAMPLE_W-1:0] sample,
    output logic                       sample_vld
);
    logic               tick;
    logic               rd_req;
    logic [PHASE_W-1:0] phase;

    nco_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    nco_phase_acc #(.STEP_W(STEP_W), .PHASE_W(PHASE_W), .SHIFT(STEP_SHIFT)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .step (step),
        .phase(phase)
    );

    nco_sine_rom #(.ADDR_W(PHASE_W), .DATA_W(SAMPLE_W)) u_rom (
        .clk  (clk),
        .rst_n(rst_n),
        .rd_en(rd_req),
        .addr (phase),
        .data (sample)
    );

    // Issue a read the clock after the phase update; strobe with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req     <= 1'b0;
            sample_vld <= 1'b0;
        end else begin
            rd_req     <= tick;
            sample_vld <= rd_req;
        end
    end

    // R1: reset clears the outputs on the next edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sample == '0) && !sample_vld);
    // R6: strobe lasts a single clock.
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);
    // R4: every strobe traces back to a divider tick two edges earlier.
    a_r4_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> $past(tick, 2));
    // R7: sample is stable between strobes.
    a_r7_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld && $past(rst_n) |-> $stable(sample));

endmodule

// File: tb/tb_sine_nco.sv
// Scoreboard bench: driver tasks push expected samples, a monitor pops and
// compares on each strobe and also checks strobe spacing and holding.
module tb_sine_nco;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [5:0]         step = 6'd5;
    logic signed [17:0] sample;
    logic               sample_vld;

    int checks = 0;
    int errors = 0;
    int model_phase = 0;
    int exp_q[$];
    string tag_q[$];
    longint cyc = 0;
    longint last_vld = 0;
    bit have_last = 0;
    logic signed [17:0] prev_sample = '0;

    always #5 clk = ~clk;

    sine_nco dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .sample    (sample),
        .sample_vld(sample_vld)
    );

    // Expected table entry: nearest integer to 131071*sin(2*pi*p/1024).
    function automatic int ref_sine(input int p);
        real ang = real'(p) * (6.283185307179586 / 1024.0);
        return int'($floor(131071.0 * $sin(ang) + 0.5));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: strobe spacing (R5, R6), holding (R7) and scoreboard (R2, R3).
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            have_last = 0;
        end else begin
            if (sample_vld) begin
                if (have_last) begin
                    check(cyc - last_vld == 195, "R5/R6 strobe spacing", int'(cyc - last_vld), 195);
                end
                have_last = 1;
                last_vld  = cyc;
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected strobe", int'(sample), 0);
                end else begin
                    check(int'(sample) == exp_q[0], tag_q[0], int'(sample), exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end else if (sample != prev_sample) begin
                check(0, "R7 sample moved without strobe", int'(sample), int'(prev_sample));
            end
        end
        prev_sample = sample;
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Driver: change step right after a strobe, then expect n samples.
    task automatic run_seg(input int s, input int n, input string tag);
        drain();
        step = 6'(s);
        for (int i = 0; i < n; i++) begin
            model_phase = (model_phase + 8 * s) % 1024;
            exp_q.push_back(ref_sine(model_phase));
            tag_q.push_back((i == 0) ? {tag, " R10 first after step change"} : tag);
        end
        drain();
    endtask

    // Reset, check cleared outputs, then first-strobe latency.
    task automatic do_reset(input int s);
        int lat;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(sample == '0, "R1 sample in reset", int'(sample), 0);
        check(sample_vld == 1'b0, "R1 strobe in reset", int'(sample_vld), 0);
        exp_q.delete();
        tag_q.delete();
        model_phase = (8 * s) % 1024;
        step = 6'(s);
        exp_q.push_back(ref_sine(model_phase));
        tag_q.push_back("R3 first sample after reset");
        rst_n = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!sample_vld && lat < 400);
        check(lat == 196, "R4 first strobe latency", lat, 196);
        drain();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(5);
        run_seg(5, 6, "R2/R3 step 5");
        run_seg(63, 20, "R9 wrap step 63");
        run_seg(0, 4, "R8 zero step constant");
        run_seg(1, 5, "R2/R3 step 1");
        run_seg(32, 5, "R3 quarter-turn step");
        do_reset(17);
        run_seg(17, 5, "R2/R3 step 17 after reset");
        run_seg(0, 3, "R8 zero step again");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule